// File: doc/BRIEF.md
# Configuration Register Bank with Burst Load

This block holds fourteen 8-bit configuration registers for a multi-channel converter front end: per-channel offset, coarse gain and fine gain, a control byte, and the settings of a clock generator (a 12-bit divider, a range field, an auxiliary field, two clock selects and two phase values). A byte-level serial front end, outside this block, reports the start of a transaction, each received byte, and the stop. The first byte of a write is a subaddress. The bytes after it either update one register or fill all fourteen registers in a fixed order.

Bit 4 of the subaddress picks the write style. With that bit clear, the low nibble names the single register that receives the next byte. With that bit set and the low nibble all ones, the following bytes fill registers 0 to 13 in order. Every field is also driven on its own parallel output. A combinational read port returns the current contents of any register.

Top module: `cfg_regbank`

## Requirements
- R1: While rst_n is low, and after it is released, registers 0, 3 and 6 hold 0x7F, registers 1, 4 and 7 hold 0x20, registers 2, 5, 8, 12 and 13 hold 0x00, register 9 holds 0x04, register 10 holds 0x61 and register 11 holds 0x90.
- R2: The first data byte of a transaction is the subaddress. Bit 4 is the mode bit, bits 3..0 are the register index, and bits 7..5 have no effect.
- R3: With mode bit 0, the next byte is stored in the indexed register only. Any further bytes in the same transaction change no register and raise no strobe.
- R4: With mode bit 1 and index 0xF, the following bytes are stored in registers 0, 1, 2, ... 13 in that order, and bytes after the fourteenth are ignored. With mode bit 1 and any other index, the data bytes of the transaction are ignored.
- R5: Registers 1, 4, 7 and 12 keep only bits 6..0. Registers 2, 5 and 8 keep only bits 4..0. Register 13 keeps only bits 5..0. Dropped bits read back as 0.
- R6: A single-style write to index 14 or 15 changes nothing and raises no strobe. rd_data returns the current contents of register rd_addr, and returns 0x00 for rd_addr 14 or 15.
- R7: txn_start or txn_stop ends the current transaction, and the next byte is taken as a subaddress. A byte that arrives in the same cycle as txn_start or txn_stop is discarded.
- R8: A byte accepted with byte_valid in cycle t is visible on rd_data and on the field outputs from cycle t+1. In cycle t+1 only, wr_stb is high and wr_idx carries the register index.
- R9: Channel c (0..2) uses registers 3c, 3c+1 and 3c+2. Its offset appears on chan_offset[8c+7:8c], its coarse gain on chan_coarse[7c+6:7c] and its fine gain on chan_fine[5c+4:5c]. ctrl_byte is register 9. pll_aux is register 10 bits 7..5 and vco_range is register 10 bits 4..3. clk_sel_a and clk_sel_b are bit 5 of registers 12 and 13, and phase_a and phase_b are bits 4..0 of those registers.
- R10: pll_divider[11:9] is register 10 bits 2..0, pll_divider[8:1] is register 11, and pll_divider[0] is register 12 bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | Transaction start indication, one cycle |
| txn_stop | input | 1 | Transaction stop indication, one cycle |
| byte_valid | input | 1 | byte_data holds a received byte |
| byte_data | input | 8 | Received byte |
| rd_addr | input | 4 | Register index to read |
| rd_data | output | 8 | Contents of register rd_addr |
| wr_stb | output | 1 | One-cycle pulse after a register write |
| wr_idx | output | 4 | Index of the register just written |
| chan_offset | output | 24 | Offsets of channels 0..2 |
| chan_coarse | output | 21 | Coarse gains of channels 0..2 |
| chan_fine | output | 15 | Fine gains of channels 0..2 |
| ctrl_byte | output | 8 | Control register |
| pll_aux | output | 3 | Auxiliary clock field |
| vco_range | output | 2 | Oscillator range field |
| pll_divider | output | 12 | Assembled divider value |
| clk_sel_a | output | 1 | Clock select A |
| clk_sel_b | output | 1 | Clock select B |
| phase_a | output | 5 | Phase A |
| phase_b | output | 5 | Phase B |

## Verification
A read and a write can hit the same register in the same cycle: the read port is combinational while the store lands on the clock edge. The bench holds rd_addr on register 4 and presents a data byte for that register. It requires the old contents in the cycle the byte is offered and the masked new contents, with wr_stb, in the cycle after. In a second scenario a byte arrives together with txn_stop. The bench checks that the byte is dropped and that the next byte is decoded as a subaddress.

// File: rtl/cfgbank_pkg.sv
// Package: shared sizes, register indices, reset values and keep-masks
// for the configuration register bank. Assumes 8-bit registers.
package cfgbank_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_REGS  = 14;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int NCH       = 3;
    localparam int REGS_PER_CH = 3;
    localparam int OFS_W     = 8;
    localparam int CRS_W     = 7;
    localparam int FIN_W     = 5;
    localparam int PH_W      = 5;
    localparam int DIV_W     = 12;
    localparam int MODE_BIT  = 4;
    localparam int REG_CTRL  = REGS_PER_CH * NCH;
    localparam int REG_PLL_HI  = REG_CTRL + 1;
    localparam int REG_PLL_MID = REG_CTRL + 2;
    localparam int REG_PH_A  = REG_CTRL + 3;
    localparam int REG_PH_B  = REG_CTRL + 4;
    localparam logic [IDX_W-1:0] BURST_NIB = '1;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_REGS - 1);

    typedef enum logic [1:0] {
        SQ_SUB,
        SQ_SINGLE,
        SQ_BURST,
        SQ_IGNORE
    } seq_state_e;

    // Reset value for register idx.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        if (idx < REG_CTRL) begin
            case (idx % REGS_PER_CH)
                0:       return 8'h7F;
                1:       return 8'h20;
                default: return 8'h00;
            endcase
        end
        case (idx)
            REG_CTRL:    return 8'h04;
            REG_PLL_HI:  return 8'h61;
            REG_PLL_MID: return 8'h90;
            default:     return 8'h00;
        endcase
    endfunction

    // Bits that register idx keeps; the rest are forced to zero.
    function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
        if (idx < REG_CTRL) begin
            case (idx % REGS_PER_CH)
                1:       return 8'h7F;
                2:       return 8'h1F;
                default: return 8'hFF;
            endcase
        end
        case (idx)
            REG_PH_A: return 8'h7F;
            REG_PH_B: return 8'h3F;
            default:  return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/cfgbank_seq.sv
// Byte sequencer: decodes the subaddress byte and turns later bytes into
// register write requests, either one addressed write or a fixed burst.
// Assumes start/stop indications take priority over a byte in the same cycle.
module cfgbank_seq
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_stop,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    seq_state_e       state, nxt_state;
    logic [IDX_W-1:0] cur_idx, nxt_idx;
    logic [IDX_W-1:0] sub_nib;
    logic             sub_mode;
    logic             unused_sub_hi;

    assign sub_nib       = byte_data[IDX_W-1:0];
    assign sub_mode      = byte_data[MODE_BIT];
    assign unused_sub_hi = ^byte_data[BYTE_W-1:MODE_BIT+1];

    // Next-state and write-request decode for each incoming byte.
    always_comb begin
        nxt_state = state;
        nxt_idx   = cur_idx;
        wr_en     = 1'b0;
        wr_idx    = cur_idx;
        wr_data   = byte_data;
        if (txn_start || txn_stop) begin
            nxt_state = SQ_SUB;
        end else if (byte_valid) begin
            case (state)
                SQ_SUB: begin
                    if (!sub_mode) begin
                        if (sub_nib <= LAST_IDX) begin
                            nxt_state = SQ_SINGLE;
                            nxt_idx   = sub_nib;
                        end else begin
                            nxt_state = SQ_IGNORE;
                        end
                    end else if (sub_nib == BURST_NIB) begin
                        nxt_state = SQ_BURST;
                        nxt_idx   = '0;
                    end else begin
                        nxt_state = SQ_IGNORE;
                    end
                end
                SQ_SINGLE: begin
                    wr_en     = 1'b1;
                    nxt_state = SQ_IGNORE;
                end
                SQ_BURST: begin
                    wr_en = 1'b1;
                    if (cur_idx == LAST_IDX) begin
                        nxt_state = SQ_IGNORE;
                    end else begin
                        nxt_idx = cur_idx + 1'b1;
                    end
                end
                default: begin
                    nxt_state = SQ_IGNORE;
                end
            endcase
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_SUB;
            cur_idx <= '0;
        end else begin
            state   <= nxt_state;
            cur_idx <= nxt_idx;
        end
    end
endmodule

// File: rtl/cfgbank_regfile.sv
// Register storage: one masked register per index with its own reset
// value, plus the registered write strobe and index. Assumes wr_idx is
// meaningful only while wr_en is high.
module cfgbank_regfile
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] regs [NUM_REGS],
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_stb_idx
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] RST_VAL = reg_default(g);
        localparam logic [BYTE_W-1:0] KEEP    = reg_mask(g);
        // Store the masked byte when this index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= RST_VAL;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs[g] <= wr_data & KEEP;
            end
        end
    end

    // One-cycle strobe and index after each completed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb     <= 1'b0;
            wr_stb_idx <= '0;
        end else begin
            wr_stb <= wr_en;
            if (wr_en) begin
                wr_stb_idx <= wr_idx;
            end
        end
    end
endmodule

// File: rtl/cfgbank_fields.sv
// Field unpacking and read mux: drives every configuration field from the
// register array and returns the register selected by rd_addr. Pure logic.
module cfgbank_fields
    import cfgbank_pkg::*;
(
    input  logic [BYTE_W-1:0]    regs [NUM_REGS],
    input  logic [IDX_W-1:0]     rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NCH*OFS_W-1:0] chan_offset,
    output logic [NCH*CRS_W-1:0] chan_coarse,
    output logic [NCH*FIN_W-1:0] chan_fine,
    output logic [BYTE_W-1:0]    ctrl_byte,
    output logic [2:0]           pll_aux,
    output logic [1:0]           vco_range,
    output logic [DIV_W-1:0]     pll_divider,
    output logic                 clk_sel_a,
    output logic                 clk_sel_b,
    output logic [PH_W-1:0]      phase_a,
    output logic [PH_W-1:0]      phase_b
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic unused_ch_bits;
        assign chan_offset[c*OFS_W +: OFS_W] = regs[REGS_PER_CH*c];
        assign chan_coarse[c*CRS_W +: CRS_W] = regs[REGS_PER_CH*c+1][CRS_W-1:0];
        assign chan_fine[c*FIN_W +: FIN_W]   = regs[REGS_PER_CH*c+2][FIN_W-1:0];
        assign unused_ch_bits = ^{regs[REGS_PER_CH*c+1][BYTE_W-1:CRS_W],
                                  regs[REGS_PER_CH*c+2][BYTE_W-1:FIN_W]};
    end

    logic unused_misc_bits;
    assign ctrl_byte   = regs[REG_CTRL];
    assign pll_aux     = regs[REG_PLL_HI][7:5];
    assign vco_range   = regs[REG_PLL_HI][4:3];
    assign pll_divider = {regs[REG_PLL_HI][2:0], regs[REG_PLL_MID], regs[REG_PH_A][6]};
    assign clk_sel_a   = regs[REG_PH_A][5];
    assign clk_sel_b   = regs[REG_PH_B][5];
    assign phase_a     = regs[REG_PH_A][PH_W-1:0];
    assign phase_b     = regs[REG_PH_B][PH_W-1:0];
    assign unused_misc_bits = ^{regs[REG_PH_A][7], regs[REG_PH_B][7:6]};

    // Read mux: unmapped indices return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr <= LAST_IDX) begin
            rd_data = regs[rd_addr];
        end
    end
endmodule

// File: rtl/cfg_regbank.sv
// Top: configuration register bank fed by a byte-level serial front end.
// Supports single-register and burst writes chosen by the subaddress mode
// bit, a combinational read port and parallel field outputs.
// Assumes the front end presents one byte per byte_valid pulse.
module cfg_regbank
    import cfgbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 txn_start,
    input  logic                 txn_stop,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    input  logic [3:0]           rd_addr,
    output logic [7:0]           rd_data,
    output logic                 wr_stb,
    output logic [3:0]           wr_idx,
    output logic [23:0]          chan_offset,
    output logic [20:0]          chan_coarse,
    output logic [14:0]          chan_fine,
    output logic [7:0]           ctrl_byte,
    output logic [2:0]           pll_aux,
    output logic [1:0]           vco_range,
    output logic [11:0]          pll_divider,
    output logic                 clk_sel_a,
    output logic                 clk_sel_b,
    output logic [4:0]           phase_a,
    output logic [4:0]           phase_b
);
    logic              seq_wr_en;
    logic [IDX_W-1:0]  seq_wr_idx;
    logic [BYTE_W-1:0] seq_wr_data;
    logic [BYTE_W-1:0] regs [NUM_REGS];

    cfgbank_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .txn_stop   (txn_stop),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .wr_en      (seq_wr_en),
        .wr_idx     (seq_wr_idx),
        .wr_data    (seq_wr_data)
    );

    cfgbank_regfile i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (seq_wr_en),
        .wr_idx     (seq_wr_idx),
        .wr_data    (seq_wr_data),
        .regs       (regs),
        .wr_stb     (wr_stb),
        .wr_stb_idx (wr_idx)
    );

    cfgbank_fields i_fields (
        .regs        (regs),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .chan_offset (chan_offset),
        .chan_coarse (chan_coarse),
        .chan_fine   (chan_fine),
        .ctrl_byte   (ctrl_byte),
        .pll_aux     (pll_aux),
        .vco_range   (vco_range),
        .pll_divider (pll_divider),
        .clk_sel_a   (clk_sel_a),
        .clk_sel_b   (clk_sel_b),
        .phase_a     (phase_a),
        .phase_b     (phase_b)
    );
endmodule

// File: rtl/cfgbank_chk.sv
// Checker: temporal properties of the register bank, observed at its ports.
// Assumes a synchronous active-low reset.
module cfgbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        txn_start,
    input logic        txn_stop,
    input logic        byte_valid,
    input logic [3:0]  rd_addr,
    input logic [7:0]  rd_data,
    input logic        wr_stb,
    input logic [3:0]  wr_idx,
    input logic [23:0] chan_offset,
    input logic [11:0] pll_divider
);
    // R8: a strobe follows a byte that was not paired with start/stop
    a_r8_strobe_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(byte_valid && !txn_start && !txn_stop));

    // R6: strobe never names an unmapped register
    a_r6_strobe_idx_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_idx <= 4'd13));

    // R6: unmapped reads return zero
    a_r6_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= 4'd14) |-> (rd_data == 8'h00));

    // R5: coarse gain registers never hold bit 7
    a_r5_coarse_bit7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr == 4'd1) || (rd_addr == 4'd4) || (rd_addr == 4'd7)) |-> (rd_data[7] == 1'b0));

    // R5: fine gain registers never hold bits 7..5
    a_r5_fine_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr == 4'd2) || (rd_addr == 4'd5) || (rd_addr == 4'd8)) |-> (rd_data[7:5] == 3'b000));

    // R7: a start discards any byte in its cycle
    a_r7_start_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> !wr_stb);

    // R8: without a byte, the contents stay put
    a_r8_hold_without_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> ($stable(pll_divider) && $stable(chan_offset)));

    // R10: divider bit 0 agrees with register 12 bit 6 on the read port
    a_r10_divider_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 4'd12) |-> (pll_divider[0] == rd_data[6]));
endmodule

bind cfg_regbank cfgbank_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_start   (txn_start),
    .txn_stop    (txn_stop),
    .byte_valid  (byte_valid),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_stb      (wr_stb),
    .wr_idx      (wr_idx),
    .chan_offset (chan_offset),
    .pll_divider (pll_divider)
);

// File: tb/test_cfg_regbank.sv
// Directed bench for cfg_regbank: one task per scenario, each checking itself.
module test_cfg_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0;
    logic        txn_stop = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [3:0]  rd_addr = 4'd0;
    logic [7:0]  rd_data;
    logic        wr_stb;
    logic [3:0]  wr_idx;
    logic [23:0] chan_offset;
    logic [20:0] chan_coarse;
    logic [14:0] chan_fine;
    logic [7:0]  ctrl_byte;
    logic [2:0]  pll_aux;
    logic [1:0]  vco_range;
    logic [11:0] pll_divider;
    logic        clk_sel_a, clk_sel_b;
    logic [4:0]  phase_a, phase_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] model [14];
    logic       got_stb;
    logic [3:0] got_idx;

    always #5 clk = ~clk;

    cfg_regbank i_cfg_regbank (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .chan_offset(chan_offset), .chan_coarse(chan_coarse), .chan_fine(chan_fine),
        .ctrl_byte(ctrl_byte), .pll_aux(pll_aux), .vco_range(vco_range),
        .pll_divider(pll_divider), .clk_sel_a(clk_sel_a), .clk_sel_b(clk_sel_b),
        .phase_a(phase_a), .phase_b(phase_b)
    );

    function automatic logic [7:0] exp_reset(input int i);
        case (i)
            0, 3, 6: return 8'h7F;
            1, 4, 7: return 8'h20;
            9:       return 8'h04;
            10:      return 8'h61;
            11:      return 8'h90;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_keep(input int i);
        case (i)
            1, 4, 7, 12: return 8'h7F;
            2, 5, 8:     return 8'h1F;
            13:          return 8'h3F;
            default:     return 8'hFF;
        endcase
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); txn_start = 1'b1;
        @(negedge clk); txn_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); txn_stop = 1'b1;
        @(negedge clk); txn_stop = 1'b0;
    endtask

    // Present one byte; capture the strobe in the following cycle.
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
        got_stb = wr_stb; got_idx = wr_idx;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] e, input string what);
        rd_addr = 4'(a);
        #1;
        chk(32'(rd_data), 32'(e), what);
    endtask

    task automatic all_regs_chk(input string what);
        for (int i = 0; i < 16; i++) begin
            rd_chk(i, (i < 14) ? model[i] : 8'h00, $sformatf("%s reg %0d", what, i));
        end
    endtask

    task automatic fields_chk(input string what);
        for (int c = 0; c < 3; c++) begin
            chk(32'(chan_offset[8*c +: 8]), 32'(model[3*c]), $sformatf("R9 %s offset ch%0d", what, c));
            chk(32'(chan_coarse[7*c +: 7]), 32'(model[3*c+1][6:0]), $sformatf("R9 %s coarse ch%0d", what, c));
            chk(32'(chan_fine[5*c +: 5]), 32'(model[3*c+2][4:0]), $sformatf("R9 %s fine ch%0d", what, c));
        end
        chk(32'(ctrl_byte), 32'(model[9]), {"R9 ctrl ", what});
        chk(32'(pll_aux), 32'(model[10][7:5]), {"R9 aux ", what});
        chk(32'(vco_range), 32'(model[10][4:3]), {"R9 vco ", what});
        chk(32'(clk_sel_a), 32'(model[12][5]), {"R9 clk_sel_a ", what});
        chk(32'(clk_sel_b), 32'(model[13][5]), {"R9 clk_sel_b ", what});
        chk(32'(phase_a), 32'(model[12][4:0]), {"R9 phase_a ", what});
        chk(32'(phase_b), 32'(model[13][4:0]), {"R9 phase_b ", what});
        chk(32'(pll_divider), 32'({model[10][2:0], model[11], model[12][6]}), {"R10 divider ", what});
    endtask

    task automatic t_reset();
        for (int i = 0; i < 14; i++) model[i] = exp_reset(i);
        all_regs_chk("R1 reset");
        fields_chk("reset");
        chk(32'(pll_divider), 32'h320, "R10 divider reset value");
        chk(32'(wr_stb), 32'h0, "R8 no strobe after reset");
    endtask

    task automatic t_single();
        pulse_start();
        send_byte(8'h02);
        send_byte(8'hFF);
        model[2] = 8'hFF & exp_keep(2);
        chk(32'(got_stb), 32'h1, "R8 strobe single write");
        chk(32'(got_idx), 32'h2, "R8 strobe index single write");
        rd_chk(2, model[2], "R5 fine masked");
        send_byte(8'h00);
        chk(32'(got_stb), 32'h0, "R3 extra byte no strobe");
        rd_chk(2, model[2], "R3 extra byte ignored");
        pulse_stop();
        pulse_start();
        send_byte(8'hE1);
        send_byte(8'hFF);
        model[1] = 8'hFF & exp_keep(1);
        chk(32'(got_idx), 32'h1, "R2 high subaddress bits ignored");
        rd_chk(1, 8'h7F, "R5 coarse masked");
        pulse_stop();
        all_regs_chk("R3 after single");
    endtask

    task automatic t_burst();
        pulse_start();
        send_byte(8'h1F);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'(i * 37 + 5);
            send_byte(v);
            if (i < 14) begin
                model[i] = v & exp_keep(i);
                chk(32'(got_stb), 32'h1, $sformatf("R4 burst strobe byte %0d", i));
                chk(32'(got_idx), 32'(i), $sformatf("R4 burst order byte %0d", i));
            end else begin
                chk(32'(got_stb), 32'h0, $sformatf("R4 burst overflow byte %0d", i));
            end
        end
        pulse_stop();
        all_regs_chk("R4 burst");
        fields_chk("burst");
        chk(32'(pll_divider), 32'hF39, "R10 divider after burst");
    endtask

    task automatic t_burst_other_nibble();
        pulse_start();
        send_byte(8'h15);
        send_byte(8'h00);
        chk(32'(got_stb), 32'h0, "R4 mode 1 other nibble no strobe");
        pulse_stop();
        all_regs_chk("R4 mode 1 other nibble");
    endtask

    task automatic t_unmapped();
        pulse_start();
        send_byte(8'h0E);
        send_byte(8'h33);
        chk(32'(got_stb), 32'h0, "R6 index 14 no strobe");
        pulse_stop();
        pulse_start();
        send_byte(8'h0F);
        send_byte(8'h44);
        chk(32'(got_stb), 32'h0, "R6 index 15 no strobe");
        pulse_stop();
        all_regs_chk("R6 unmapped");
    endtask

    task automatic t_restart();
        pulse_start();
        send_byte(8'h00);
        pulse_start();
        send_byte(8'h03);
        chk(32'(got_stb), 32'h0, "R7 byte after restart is subaddress");
        send_byte(8'h55);
        model[3] = 8'h55;
        chk(32'(got_idx), 32'h3, "R7 restart target index");
        rd_chk(3, 8'h55, "R7 restart write");
        rd_chk(0, model[0], "R7 register 0 untouched");
        pulse_stop();
        pulse_start();
        send_byte(8'h09);
        @(negedge clk); byte_valid = 1'b1; byte_data = 8'hAA; txn_stop = 1'b1;
        @(negedge clk); byte_valid = 1'b0; txn_stop = 1'b0;
        chk(32'(wr_stb), 32'h0, "R7 byte with stop dropped");
        rd_chk(9, model[9], "R7 ctrl unchanged after stop byte");
        send_byte(8'h0D);
        send_byte(8'hFF);
        model[13] = 8'h3F;
        chk(32'(got_idx), 32'hD, "R7 post-stop byte was subaddress");
        rd_chk(13, 8'h3F, "R5 reg 13 masked");
    endtask

    task automatic t_read_during_write();
        logic [7:0] old;
        pulse_start();
        send_byte(8'h04);
        old = model[4];
        @(negedge clk); rd_addr = 4'd4; byte_valid = 1'b1; byte_data = 8'hC3;
        #1;
        chk(32'(rd_data), 32'(old), "R8 old value in byte cycle");
        chk(32'(wr_stb), 32'h0, "R8 no strobe in byte cycle");
        @(negedge clk); byte_valid = 1'b0;
        model[4] = 8'h43;
        chk(32'(rd_data), 32'h43, "R8 new value next cycle");
        chk(32'(wr_stb), 32'h1, "R8 strobe next cycle");
        chk(32'(chan_coarse[7 +: 7]), 32'h43, "R9 coarse ch1 updated");
        @(negedge clk);
        chk(32'(wr_stb), 32'h0, "R8 strobe lasts one cycle");
        pulse_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_burst_other_nibble();
        t_unmapped();
        t_restart();
        t_read_during_write();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run not finished, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule